// File: doc/BRIEF.md
# Byte-Lane Steering Controller With Read Swap

This block decides, for every bus cycle, which path carries each byte of a 16-bit multiplexed CPU address/data bus. Offboard transfers pass through two straight lane buffers to the expansion bus, one buffer per byte lane. Onboard transfers go to local memory through two bank selects. A third path, the swap path, is used only on offboard byte reads at even addresses. It copies the low byte of the expansion bus onto the upper half of the CPU bus, and while it does so both straight buffers are shut off.

Address bit 0 is captured while the address strobe is high and is held for the rest of the cycle. All routing decisions are combinational from that held bit and the live control inputs: read/write, byte/word, data strobe and onboard/offboard. The buffers are modelled as multiplexed data paths, and any lane that has no driver reads as zero.

Top module: `lane_steer`

## Requirements
- R1: On an onboard word transfer with the data strobe high, both `bank_hi_o` and `bank_lo_o` are 1, for reads and for writes.
- R2: On an onboard byte transfer with the data strobe high, a held address bit of 0 gives `bank_hi_o`=1 and `bank_lo_o`=0. A held bit of 1 gives `bank_hi_o`=0 and `bank_lo_o`=1.
- R3: `swap_en_o` is 1 exactly when the data strobe is high, the cycle is offboard, `rd_i`=1 (read), `byte_i`=1 (byte) and the held address bit is 0.
- R4: While `swap_en_o`=1, `cpu_ad_o[15:8]` equals `exp_ad_i[7:0]` and `cpu_ad_o[7:0]` is 0.
- R5: While `swap_en_o`=1, `hi_lane_en_o` and `lo_lane_en_o` are both 0. On any other offboard cycle with the data strobe high, both are 1.
- R6: With `ds_i`=0, every enable and bank select is 0 and both data outputs are 0.
- R7: The held address bit loads `adr0_i` on a rising clock edge where `as_i`=1. It keeps its value while `as_i`=0, and reset clears it to 0.
- R8: On straight offboard reads `cpu_ad_o` equals `exp_ad_i`. On offboard writes `exp_ad_o` equals `cpu_ad_i`. On onboard cycles both data outputs are 0 and the lane enables are 0. On offboard cycles both bank selects are 0.
- R9: No CPU bus byte lane ever has more than one driver during a read. The drivers counted are the straight lane buffer, the swap path and the memory bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Address strobe; captures adr0_i |
| adr0_i | input | 1 | Address bit 0 from the CPU bus |
| rd_i | input | 1 | 1 = read, 0 = write |
| byte_i | input | 1 | 1 = byte transfer, 0 = word |
| ds_i | input | 1 | Data strobe, active high |
| offboard_i | input | 1 | 1 = expansion bus target, 0 = local memory |
| cpu_ad_i | input | 16 | Data driven by the CPU on writes |
| exp_ad_i | input | 16 | Data from the expansion bus on reads |
| hi_lane_en_o | output | 1 | Straight buffer enable, bits 15:8 |
| lo_lane_en_o | output | 1 | Straight buffer enable, bits 7:0 |
| swap_en_o | output | 1 | Swap path enable |
| bank_hi_o | output | 1 | Local memory high-byte bank select |
| bank_lo_o | output | 1 | Local memory low-byte bank select |
| cpu_ad_o | output | 16 | Data returned to the CPU bus |
| exp_ad_o | output | 16 | Data driven onto the expansion bus |

## Verification
The bench targets the even/odd split on offboard byte reads. A design that decoded the address bit backwards would swap on odd addresses, or would leave the straight high buffer fighting the swap path on the upper lane. Byte writes at even addresses are checked to stay on the straight path, because a swap condition missing its read term would corrupt write data. The address bit is wiggled while the address strobe is low, to catch a latch that follows the live pin. Reset is applied after a 1 has been captured, to catch a latch that reset does not clear.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned HI_LANE   = 1;
  localparam int unsigned LO_LANE   = 0;

  typedef struct packed {
    logic [NUM_LANES-1:0] lane_en;
    logic                 swap_en;
    logic [NUM_LANES-1:0] bank_sel;
  } steer_ctl_t;
endpackage

// File: rtl/lane_addr_latch.sv
module lane_addr_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_i,
  input  logic adr0_i,
  output logic lad_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lad_o <= 1'b0;
    else if (as_i) lad_o <= adr0_i;
  end
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_steer_pkg::*;
(
  input  logic       lad_i,
  input  logic       rd_i,
  input  logic       byte_i,
  input  logic       ds_i,
  input  logic       offboard_i,
  output steer_ctl_t ctl_o
);
  logic swap_req;
  logic off_act;
  logic on_act;

  // even-address byte read wants the swap path
  assign swap_req = rd_i & byte_i & ~lad_i;
  assign off_act  = ds_i & offboard_i;
  assign on_act   = ds_i & ~offboard_i;

  always_comb begin
    ctl_o.swap_en           = off_act & swap_req;
    ctl_o.lane_en           = {NUM_LANES{off_act & ~swap_req}};
    ctl_o.bank_sel[HI_LANE] = on_act & (~byte_i | ~lad_i);
    ctl_o.bank_sel[LO_LANE] = on_act & (~byte_i |  lad_i);
  end
endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_steer_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [NUM_LANES-1:0] lane_en_i,
  input  logic                 swap_en_i,
  input  logic                 rd_i,
  input  logic [DATA_W-1:0]    cpu_ad_i,
  input  logic [DATA_W-1:0]    exp_ad_i,
  output logic [DATA_W-1:0]    cpu_ad_o,
  output logic [DATA_W-1:0]    exp_ad_o
);
  localparam int unsigned LANE_W = DATA_W / NUM_LANES;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] exp_l;
    logic [LANE_W-1:0] cpu_l;
    logic              rd_str;
    logic              wr_str;

    assign exp_l  = exp_ad_i[l*LANE_W +: LANE_W];
    assign cpu_l  = cpu_ad_i[l*LANE_W +: LANE_W];
    assign rd_str = lane_en_i[l] & rd_i;
    assign wr_str = lane_en_i[l] & ~rd_i;

    if (l == HI_LANE) begin : g_swap
      always_comb begin
        if (swap_en_i)   cpu_ad_o[l*LANE_W +: LANE_W] = exp_ad_i[LO_LANE*LANE_W +: LANE_W];
        else if (rd_str) cpu_ad_o[l*LANE_W +: LANE_W] = exp_l;
        else             cpu_ad_o[l*LANE_W +: LANE_W] = '0;
      end
    end else begin : g_plain
      assign cpu_ad_o[l*LANE_W +: LANE_W] = rd_str ? exp_l : '0;
    end

    assign exp_ad_o[l*LANE_W +: LANE_W] = wr_str ? cpu_l : '0;
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lane_steer_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_i,
  input  logic              adr0_i,
  input  logic              rd_i,
  input  logic              byte_i,
  input  logic              ds_i,
  input  logic              offboard_i,
  input  logic [DATA_W-1:0] cpu_ad_i,
  input  logic [DATA_W-1:0] exp_ad_i,
  output logic              hi_lane_en_o,
  output logic              lo_lane_en_o,
  output logic              swap_en_o,
  output logic              bank_hi_o,
  output logic              bank_lo_o,
  output logic [DATA_W-1:0] cpu_ad_o,
  output logic [DATA_W-1:0] exp_ad_o
);
  logic       lad_q;
  steer_ctl_t ctl;

  lane_addr_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .as_i   (as_i),
    .adr0_i (adr0_i),
    .lad_o  (lad_q)
  );

  lane_ctrl u_ctrl (
    .lad_i      (lad_q),
    .rd_i       (rd_i),
    .byte_i     (byte_i),
    .ds_i       (ds_i),
    .offboard_i (offboard_i),
    .ctl_o      (ctl)
  );

  lane_datapath #(.DATA_W(DATA_W)) u_dp (
    .lane_en_i (ctl.lane_en),
    .swap_en_i (ctl.swap_en),
    .rd_i      (rd_i),
    .cpu_ad_i  (cpu_ad_i),
    .exp_ad_i  (exp_ad_i),
    .cpu_ad_o  (cpu_ad_o),
    .exp_ad_o  (exp_ad_o)
  );

  assign hi_lane_en_o = ctl.lane_en[HI_LANE];
  assign lo_lane_en_o = ctl.lane_en[LO_LANE];
  assign swap_en_o    = ctl.swap_en;
  assign bank_hi_o    = ctl.bank_sel[HI_LANE];
  assign bank_lo_o    = ctl.bank_sel[LO_LANE];
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic as_i,
  input logic rd_i,
  input logic byte_i,
  input logic ds_i,
  input logic offboard_i,
  input logic lad_q,
  input logic hi_lane_en_o,
  input logic lo_lane_en_o,
  input logic swap_en_o,
  input logic bank_hi_o,
  input logic bank_lo_o
);
  a_r1_word_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_i && !offboard_i && !byte_i) |-> (bank_hi_o && bank_lo_o));

  a_r2_byte_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_i && !offboard_i && byte_i) |-> ($countones({bank_hi_o, bank_lo_o}) == 1));

  a_r3_swap_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_en_o |-> (rd_i && byte_i && offboard_i && ds_i && !lad_q));

  a_r5_swap_kills_straight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_en_o |-> (!hi_lane_en_o && !lo_lane_en_o));

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_i |-> !(hi_lane_en_o || lo_lane_en_o || swap_en_o || bank_hi_o || bank_lo_o));

  a_r7_lad_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> $stable(lad_q));

  a_r9_hi_lane_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hi_lane_en_o & rd_i, swap_en_o, bank_hi_o & rd_i}) <= 1);

  a_r9_lo_lane_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({lo_lane_en_o & rd_i, bank_lo_o & rd_i}) <= 1);
endmodule

bind lane_steer lane_steer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .as_i         (as_i),
  .rd_i         (rd_i),
  .byte_i       (byte_i),
  .ds_i         (ds_i),
  .offboard_i   (offboard_i),
  .lad_q        (lad_q),
  .hi_lane_en_o (hi_lane_en_o),
  .lo_lane_en_o (lo_lane_en_o),
  .swap_en_o    (swap_en_o),
  .bank_hi_o    (bank_hi_o),
  .bank_lo_o    (bank_lo_o)
);

// File: tb/lane_steer_bench.sv
`timescale 1ns/1ps
module lane_steer_bench;
  localparam logic [15:0] EXP_V = 16'hA55A;
  localparam logic [15:0] CPU_V = 16'h3CC3;
  // {lad, rd, byte, ds, off, hi_en, lo_en, swap, bank_hi, bank_lo}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    10'b01111_00100,  // R3 R4 R5 swap
    10'b11111_11000,  // R5 R8 odd byte read offboard
    10'b01011_11000,  // R8 word read offboard
    10'b00111_11000,  // R3 R8 even byte write stays straight
    10'b01101_00000,  // R6 ds low
    10'b01010_00011,  // R1 word read onboard
    10'b00010_00011,  // R1 word write onboard
    10'b01110_00010,  // R2 even byte onboard
    10'b10110_00001,  // R2 odd byte onboard
    10'b11000_00000   // R6 ds low onboard
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic as_i = 1'b0, adr0_i = 1'b0, rd_i = 1'b0, byte_i = 1'b0, ds_i = 1'b0, offboard_i = 1'b0;
  logic [15:0] cpu_ad_i = '0, exp_ad_i = '0;
  logic hi_lane_en_o, lo_lane_en_o, swap_en_o, bank_hi_o, bank_lo_o;
  logic [15:0] cpu_ad_o, exp_ad_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  lane_steer u_lane_steer (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic capture(input logic a0);
    @(negedge clk_i); as_i = 1'b1; adr0_i = a0; ds_i = 1'b0;
    @(negedge clk_i); as_i = 1'b0; adr0_i = ~a0;  // wiggle to prove hold (R7)
  endtask

  task automatic drive(input logic rd, input logic byt, input logic ds, input logic off);
    rd_i = rd; byte_i = byt; ds_i = ds; offboard_i = off;
    cpu_ad_i = CPU_V; exp_ad_i = EXP_V;
    #1;
  endtask

  initial begin : watchdog
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ec, ee;
    #12;
    // reset state: R6 all quiet with ds low
    chk("R6 reset enables", {hi_lane_en_o, lo_lane_en_o, swap_en_o, bank_hi_o, bank_lo_o}, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      capture(VEC[i][9]);
      drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk($sformatf("R1/R2/R3/R5/R6 vec%0d ctl", i),
          {hi_lane_en_o, lo_lane_en_o, swap_en_o, bank_hi_o, bank_lo_o}, VEC[i][4:0]);
      // R4 R8 expected data
      if (VEC[i][2])                 ec = {EXP_V[7:0], 8'h00};
      else if (VEC[i][4] && VEC[i][8]) ec = EXP_V;
      else                           ec = '0;
      ee = (VEC[i][4] && !VEC[i][8]) ? CPU_V : '0;
      chk($sformatf("R4/R8 vec%0d cpu_ad_o", i), cpu_ad_o, ec);
      chk($sformatf("R8 vec%0d exp_ad_o", i), exp_ad_o, ee);
    end

    // R7: held bit survives many cycles of wiggling adr0 with as low
    capture(1'b1);
    repeat (3) begin @(negedge clk_i); adr0_i = ~adr0_i; end
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R7 hold odd", {bank_hi_o, bank_lo_o}, 2'b01);

    // R7: reset clears the captured 1
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R6 reset quiet", {hi_lane_en_o, lo_lane_en_o, swap_en_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1; adr0_i = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R7 reset clears lad swap", swap_en_o, 1'b1);
    chk("R4 swap data after reset", cpu_ad_o, {EXP_V[7:0], 8'h00});

    // R3: swap follows ds within a held cycle
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R3 swap drops with ds", swap_en_o, 1'b0);
    chk("R6 data zero ds low", cpu_ad_o, 16'h0);

    // R5: different data pattern on straight word read
    exp_ad_i = 16'h1234; rd_i = 1'b1; byte_i = 1'b0; ds_i = 1'b1; #1;
    chk("R5 straight word read", {hi_lane_en_o, lo_lane_en_o, swap_en_o}, 3'b110);
    chk("R8 word read data", cpu_ad_o, 16'h1234);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule